// File: doc/BRIEF.md
# Bit-Level I2C Serial EEPROM Slave

This block models a serial EEPROM that sits on a two-wire bus. The host drives the bus by writing clock and data levels into register bits. Each system-clock cycle the block samples those two levels and finds edges by comparing each one with its value from the previous cycle. It recognises start and stop conditions. It shifts in a control byte, any word-address bytes and any data bytes. On an open-drain data line it drives acknowledge bits and, during reads, the stored data bits.

The storage is an internal byte array. Its size is a power of two set by a parameter. The size fixes how the word address is delivered:
- Arrays under 256 bytes take the address from the upper seven bits of the control byte, and data follows directly.
- Arrays of 256 to 4095 bytes take three control-byte bits as the upper address bits, followed by one address byte.
- Arrays of 4096 bytes and more take a high address byte and then a low address byte.

The address pointer advances after every data byte and wraps at the array size.

The level seen on the bus is the wired-AND of the host level and the slave level. The block does not stretch the clock, does not model write-cycle busy time and does not compare the device-select bits.

Top module: `ser_eeprom_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_slave` = 1), and every byte of the array reads back as 0xFF until it is written.
- R2: A falling data level while the clock is high (a start condition) releases the data line, loads a count of eight bits and begins reception of a control byte.
- R3: A rising data level while the clock is high (a stop condition) releases the data line, returns the block to idle and abandons any partly received byte. Clock toggles while idle leave the data line released.
- R4: Received bits are sampled on rising clock edges, most significant bit first. After the eighth bit of a received byte, the slave drives the data line low from the next falling clock edge through the acknowledge clock. It releases the line again on the falling edge that follows.
- R5: Bit 0 of the control byte set to 1 selects a read. The byte at the current address is then shifted out most significant bit first, with a new bit placed on the line at each falling clock edge.
- R6: With fewer than 256 bytes, a write control byte carries the word address in bits [7:1], and the next byte is data.
- R7: With 256 to 4095 bytes, control-byte bits [3:1] form address bits [10:8], and one address byte supplies bits [7:0]. Address bits at or above the array size are discarded.
- R8: With 4096 bytes or more, a high address byte and then a low address byte follow the control byte. High bits at or above the array size are discarded.
- R9: After each data byte, whether read or written, the address increments and wraps from the top of the array to zero.
- R10: A written data byte is stored on the eighth rising clock edge of that byte and is returned by a later read.
- R11: The output `sda_line` is the logical AND of the host data level and the slave data level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level written by the host |
| sda_in | input | 1 | Data level driven by the host |
| sda_line | output | 1 | Resolved bus data level (wired-AND) |
| sda_slave | output | 1 | Data level driven by the slave, 1 when released |

## Verification
The assertions assume that the clock and data levels stay constant between writes. They also assume that the host changes data only while the clock is low, except when it deliberately makes a start or stop condition. Under these assumptions every change of `sda_slave` can be traced to a falling clock edge, a start or a stop. The directed bench holds each bus level for several system clocks and moves data only in the low clock phase. It switches between the three instances only while its data level is high, so a device that is not selected never sees a spurious start.

// File: rtl/ees_pkg.sv
package ees_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CTRL_ACK,
      ST_AHI,
      ST_AHI_ACK,
      ST_ALO,
      ST_ALO_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_WR,
      ST_WR_ACK
   } ees_state_e;

   typedef enum logic [1:0] {
      AM_SHORT,
      AM_ONE_BYTE,
      AM_TWO_BYTE
   } ees_amode_e;

   localparam int BITS_PER_BYTE = 8;

   function automatic ees_amode_e pick_amode(input int bytes);
      if (bytes < 256)       return AM_SHORT;
      else if (bytes < 4096) return AM_ONE_BYTE;
      else                   return AM_TWO_BYTE;
   endfunction

endpackage

// File: rtl/ees_line_watch.sv
module ees_line_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev,
   output logic sda_prev
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   // clock edge is handled first; start/stop then use the new clock level
   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_ev = scl & sda_q & ~sda;
   assign stop_ev  = scl & ~sda_q & sda;
   assign sda_prev = sda_q;

endmodule

// File: rtl/ees_byte_store.sv
module ees_byte_store #(
   parameter int BYTES = 512,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem_q [BYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < BYTES; i++) begin
            mem_q[i] <= 8'hFF;
         end
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/ees_proto_fsm.sv
module ees_proto_fsm
   import ees_pkg::*;
#(
   parameter int         AW    = 9,
   parameter ees_amode_e AMODE = AM_ONE_BYTE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_ev,
   input  logic          stop_ev,
   input  logic          bit_in,
   input  logic [7:0]    rd_data,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [7:0]    mem_wdata,
   output logic [AW-1:0] mem_raddr,
   output logic          sda_drive,
   output ees_state_e    st_o,
   output logic [3:0]    cnt_o
);

   localparam logic [3:0] CNT_LOAD = 4'(BITS_PER_BYTE);

   ees_state_e    st_q, st_d;
   logic [3:0]    cnt_q, cnt_d;
   logic [7:0]    latch_q, latch_d;
   logic [AW-1:0] addr_q, addr_d;
   logic          drv_q, drv_d;

   logic [7:0]    shifted;
   logic [AW-1:0] addr_inc;
   logic [AW-1:0] entry_addr;
   ees_state_e    entry_st;

   assign shifted  = {latch_q[6:0], bit_in};
   assign addr_inc = addr_q + AW'(1);

   // address scheme chosen by array size
   generate
      if (AMODE == AM_SHORT) begin : g_short
         assign entry_addr = AW'(latch_q[7:1]);
         assign entry_st   = ST_WR;
      end else if (AMODE == AM_ONE_BYTE) begin : g_one
         assign entry_addr = AW'({latch_q[3:1], 8'h00});
         assign entry_st   = ST_ALO;
      end else begin : g_two
         assign entry_addr = addr_q;
         assign entry_st   = ST_AHI;
      end
   endgenerate

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      latch_d   = latch_q;
      addr_d    = addr_q;
      drv_d     = drv_q;
      mem_we    = 1'b0;
      mem_raddr = addr_q;

      if (scl_rise) begin
         case (st_q)
            ST_CTRL, ST_AHI, ST_ALO, ST_WR: begin
               latch_d = shifted;
               cnt_d   = cnt_q - 4'd1;
               if (cnt_q == 4'd1) begin
                  case (st_q)
                     ST_CTRL: st_d = ST_CTRL_ACK;
                     ST_AHI: begin
                        addr_d = AW'({shifted, 8'h00});
                        st_d   = ST_AHI_ACK;
                     end
                     ST_ALO: begin
                        addr_d = addr_q | AW'(shifted);
                        st_d   = ST_ALO_ACK;
                     end
                     default: begin
                        mem_we = 1'b1;
                        st_d   = ST_WR_ACK;
                     end
                  endcase
               end
            end
            ST_CTRL_ACK: begin
               cnt_d = CNT_LOAD;
               if (latch_q[0]) begin
                  st_d    = ST_RD;
                  latch_d = rd_data;
               end else begin
                  st_d   = entry_st;
                  addr_d = entry_addr;
               end
            end
            ST_AHI_ACK: begin
               st_d  = ST_ALO;
               cnt_d = CNT_LOAD;
            end
            ST_ALO_ACK: begin
               st_d  = ST_WR;
               cnt_d = CNT_LOAD;
            end
            ST_RD: begin
               cnt_d = cnt_q - 4'd1;
               if (cnt_q == 4'd1) st_d = ST_RD_ACK;
            end
            ST_RD_ACK: begin
               st_d      = ST_RD;
               cnt_d     = CNT_LOAD;
               addr_d    = addr_inc;
               mem_raddr = addr_inc;
               latch_d   = rd_data;
            end
            ST_WR_ACK: begin
               st_d   = ST_WR;
               cnt_d  = CNT_LOAD;
               addr_d = addr_inc;
            end
            default: ;
         endcase
      end else if (scl_fall) begin
         case (st_q)
            ST_CTRL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_RD_ACK, ST_WR_ACK:
               drv_d = 1'b0;
            ST_RD: begin
               drv_d   = latch_q[7];
               latch_d = {latch_q[6:0], 1'b0};
            end
            default: drv_d = 1'b1;
         endcase
      end

      if (stop_ev) begin
         st_d  = ST_IDLE;
         drv_d = 1'b1;
      end
      if (start_ev) begin
         st_d  = ST_CTRL;
         cnt_d = CNT_LOAD;
         drv_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= 4'd0;
         latch_q <= 8'hFF;
         addr_q  <= '0;
         drv_q   <= 1'b1;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         latch_q <= latch_d;
         addr_q  <= addr_d;
         drv_q   <= drv_d;
      end
   end

   assign mem_waddr = addr_q;
   assign mem_wdata = shifted;
   assign sda_drive = drv_q;
   assign st_o      = st_q;
   assign cnt_o     = cnt_q;

endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
   import ees_pkg::*;
#(
   parameter int MEM_BYTES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_line,
   output logic sda_slave
);

   localparam int         AW    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
   localparam ees_amode_e AMODE = pick_amode(MEM_BYTES);

   generate
      if (MEM_BYTES < 2 || MEM_BYTES > 65536) begin : g_bad_range
         $error("MEM_BYTES must lie between 2 and 65536");
      end
      if ((MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_pow2
         $error("MEM_BYTES must be a power of two");
      end
   endgenerate

   logic          w_scl_rise;
   logic          w_scl_fall;
   logic          w_start_ev;
   logic          w_stop_ev;
   logic          w_bit;
   logic          w_we;
   logic [AW-1:0] w_waddr;
   logic [7:0]    w_wdata;
   logic [AW-1:0] w_raddr;
   logic [7:0]    w_rdata;
   ees_state_e    w_state;
   logic [3:0]    w_cnt;

   ees_line_watch u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_in),
      .sda      (sda_in),
      .scl_rise (w_scl_rise),
      .scl_fall (w_scl_fall),
      .start_ev (w_start_ev),
      .stop_ev  (w_stop_ev),
      .sda_prev (w_bit)
   );

   ees_proto_fsm #(
      .AW    (AW),
      .AMODE (AMODE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (w_scl_rise),
      .scl_fall  (w_scl_fall),
      .start_ev  (w_start_ev),
      .stop_ev   (w_stop_ev),
      .bit_in    (w_bit),
      .rd_data   (w_rdata),
      .mem_we    (w_we),
      .mem_waddr (w_waddr),
      .mem_wdata (w_wdata),
      .mem_raddr (w_raddr),
      .sda_drive (sda_slave),
      .st_o      (w_state),
      .cnt_o     (w_cnt)
   );

   ees_byte_store #(
      .BYTES (2 ** AW),
      .AW    (AW)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (w_we),
      .waddr (w_waddr),
      .wdata (w_wdata),
      .raddr (w_raddr),
      .rdata (w_rdata)
   );

   assign sda_line = sda_in & sda_slave;

endmodule

// File: rtl/ees_checker.sv
module ees_checker
   import ees_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       sda_slave,
   input logic       scl_fall,
   input logic       start_ev,
   input logic       stop_ev,
   input logic       mem_we,
   input ees_state_e state,
   input logic [3:0] cnt
);

   logic in_ack;
   logic in_rx;
   assign in_ack = (state == ST_CTRL_ACK) || (state == ST_AHI_ACK) || (state == ST_ALO_ACK)
                || (state == ST_RD_ACK)   || (state == ST_WR_ACK);
   assign in_rx  = (state == ST_IDLE) || (state == ST_CTRL) || (state == ST_AHI)
                || (state == ST_ALO)  || (state == ST_WR);

   // R3: stop returns to idle with the line released
   a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (state == ST_IDLE && sda_slave));

   // R3: idle holds until a start
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start_ev) |=> (state == ST_IDLE));

   // R2: start loads the bit count and releases the line
   a_r2_start_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state == ST_CTRL && cnt == 4'd8 && sda_slave));

   // R4: acknowledge is driven low from the falling edge
   a_r4_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && in_ack) |=> !sda_slave);

   // R4: receiving states release the line on a falling edge
   a_r4_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && in_rx) |=> sda_slave);

   // R4: the slave level moves only on falling edges, start or stop
   a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_fall && !start_ev && !stop_ev) |=> $stable(sda_slave));

   // R4: bit count never exceeds one byte
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd8);

   // R10: a store is followed by the write acknowledge
   a_r10_commit_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !start_ev && !stop_ev) |=> (state == ST_WR_ACK));

endmodule

bind ser_eeprom_slave ees_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_slave (sda_slave),
   .scl_fall  (w_scl_fall),
   .start_ev  (w_start_ev),
   .stop_ev   (w_stop_ev),
   .mem_we    (w_we),
   .state     (w_state),
   .cnt       (w_cnt)
);

// File: tb/test_ser_eeprom_slave.sv
module test_ser_eeprom_slave;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic drv_sda = 1'b1;
   int   sel = 1;
   int   n_chk = 0;
   int   n_err = 0;

   logic sda_h0, sda_h1, sda_h2;
   logic line0, line1, line2;
   logic slv0, slv1, slv2;

   always #5 clk = ~clk;

   assign sda_h0 = (sel == 0) ? drv_sda : 1'b1;
   assign sda_h1 = (sel == 1) ? drv_sda : 1'b1;
   assign sda_h2 = (sel == 2) ? drv_sda : 1'b1;

   ser_eeprom_slave #(.MEM_BYTES(128)) i_small (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_h0),
      .sda_line(line0), .sda_slave(slv0));

   ser_eeprom_slave #(.MEM_BYTES(512)) i_ser_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_h1),
      .sda_line(line1), .sda_slave(slv1));

   ser_eeprom_slave #(.MEM_BYTES(4096)) i_large (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_h2),
      .sda_line(line2), .sda_slave(slv2));

   function automatic logic cur_line();
      case (sel)
         0:       return line0;
         1:       return line1;
         default: return line2;
      endcase
   endfunction

   function automatic logic cur_slave();
      case (sel)
         0:       return slv0;
         1:       return slv1;
         default: return slv2;
      endcase
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic phase(input logic c, input logic d);
      @(negedge clk);
      scl     = c;
      drv_sda = d;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      phase(1'b0, 1'b1);
      phase(1'b1, 1'b1);
      phase(1'b1, 1'b0);
      phase(1'b0, 1'b0);
   endtask

   task automatic bus_stop();
      phase(1'b0, 1'b0);
      phase(1'b1, 1'b0);
      phase(1'b1, 1'b1);
   endtask

   task automatic send_byte(input logic [7:0] b, input string tag);
      for (int i = 7; i >= 0; i--) begin
         phase(1'b0, b[i]);
         phase(1'b1, b[i]);
      end
      phase(1'b0, b[0]);
      phase(1'b0, 1'b1);
      phase(1'b1, 1'b1);
      check8(tag, {7'd0, cur_line()}, 8'h00);
      phase(1'b0, 1'b1);
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic last);
      for (int i = 7; i >= 0; i--) begin
         phase(1'b1, 1'b1);
         b[i] = cur_line();
         phase(1'b0, 1'b1);
      end
      phase(1'b0, last);
      phase(1'b1, last);
      phase(1'b0, last);
      phase(1'b0, 1'b1);
   endtask

   task automatic send_addr(input int dev, input logic [15:0] a);
      bus_start();
      case (dev)
         0: send_byte({a[6:0], 1'b0}, "R6 ack short ctrl");
         1: begin
            send_byte({4'hA, a[10:8], 1'b0}, "R7 ack ctrl");
            send_byte(a[7:0], "R7 ack addr");
         end
         default: begin
            send_byte(8'hA0, "R8 ack ctrl");
            send_byte(a[15:8], "R8 ack addr hi");
            send_byte(a[7:0], "R8 ack addr lo");
         end
      endcase
   endtask

   task automatic start_read();
      bus_start();
      send_byte(8'hA1, "R5 ack read ctrl");
   endtask

   task automatic t_reset();
      sel = 1;
      check8("R1 slave released", {7'd0, slv0 & slv1 & slv2}, 8'h01);
      check8("R11 line both high", {7'd0, line1}, 8'h01);
      phase(1'b0, 1'b1);
      phase(1'b1, 1'b1);
      phase(1'b1, 1'b0);
      check8("R11 line host low", {7'd0, cur_line()}, 8'h00);
      check8("R2 released after start", {7'd0, cur_slave()}, 8'h01);
      phase(1'b0, 1'b0);
      bus_stop();
   endtask

   task automatic t_mid_write_read();
      logic [7:0] b;
      sel = 1;
      send_addr(1, 16'h0110);
      send_byte(8'h5A, "R10 ack data0");
      send_byte(8'hC3, "R10 ack data1");
      check8("R4 release after ack", {7'd0, cur_slave()}, 8'h01);
      bus_stop();
      send_addr(1, 16'h0110);
      start_read();
      recv_byte(b, 1'b0); check8("R5 R7 read 0x110", b, 8'h5A);
      recv_byte(b, 1'b0); check8("R9 R10 read 0x111", b, 8'hC3);
      recv_byte(b, 1'b1); check8("R1 unwritten 0x112", b, 8'hFF);
      bus_stop();
   endtask

   task automatic t_mid_wrap();
      logic [7:0] b;
      sel = 1;
      send_addr(1, 16'h01FF);
      send_byte(8'h11, "R9 ack top");
      send_byte(8'h22, "R9 ack wrapped");
      bus_stop();
      send_addr(1, 16'h07FF);
      start_read();
      recv_byte(b, 1'b0); check8("R7 masked read 0x1FF", b, 8'h11);
      recv_byte(b, 1'b1); check8("R9 wrap read 0x000", b, 8'h22);
      bus_stop();
   endtask

   task automatic t_small();
      logic [7:0] b;
      phase(1'b1, 1'b1);
      sel = 0;
      send_addr(0, 16'h0005);
      send_byte(8'h77, "R6 ack d0");
      send_byte(8'h88, "R6 ack d1");
      bus_stop();
      send_addr(0, 16'h0005);
      start_read();
      recv_byte(b, 1'b0); check8("R6 read 0x05", b, 8'h77);
      recv_byte(b, 1'b1); check8("R6 read 0x06", b, 8'h88);
      bus_stop();
      send_addr(0, 16'h007F);
      send_byte(8'h31, "R9 ack small top");
      send_byte(8'h32, "R9 ack small wrap");
      bus_stop();
      send_addr(0, 16'h007F);
      start_read();
      recv_byte(b, 1'b0); check8("R9 small read 0x7F", b, 8'h31);
      recv_byte(b, 1'b0); check8("R9 small read 0x00", b, 8'h32);
      recv_byte(b, 1'b1); check8("R1 small read 0x01", b, 8'hFF);
      bus_stop();
   endtask

   task automatic t_large();
      logic [7:0] b;
      phase(1'b1, 1'b1);
      sel = 2;
      send_addr(2, 16'h0ABC);
      send_byte(8'hE7, "R8 ack data");
      bus_stop();
      send_addr(2, 16'hFABC);
      start_read();
      recv_byte(b, 1'b0); check8("R8 masked read 0xABC", b, 8'hE7);
      recv_byte(b, 1'b1); check8("R9 large read 0xABD", b, 8'hFF);
      bus_stop();
   endtask

   task automatic t_stop_abort();
      logic [7:0] b;
      phase(1'b1, 1'b1);
      sel = 1;
      send_addr(1, 16'h0140);
      for (int i = 0; i < 4; i++) begin
         phase(1'b0, 1'b0);
         phase(1'b1, 1'b0);
      end
      bus_stop();
      for (int i = 0; i < 3; i++) begin
         phase(1'b0, 1'b1);
         check8("R3 idle low clock", {7'd0, cur_line()}, 8'h01);
         phase(1'b1, 1'b1);
         check8("R3 idle high clock", {7'd0, cur_line()}, 8'h01);
      end
      send_addr(1, 16'h0140);
      start_read();
      recv_byte(b, 1'b1); check8("R3 aborted byte not stored", b, 8'hFF);
      bus_stop();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_mid_write_read();
      t_mid_wrap();
      t_small();
      t_large();
      t_stop_abort();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule